// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the integer registers and the status word of a 32-bit processor whose visible register set depends on the operating mode. A 4-bit register number selects one of sixteen visible registers. The block maps that number to one of thirty physical storage words using the current mode. Index 15 reads a program-counter register, which loads a new value from the fetch logic on every clock.

Two combinational read ports and one clocked write port serve the datapath. The current status word holds four condition flags, two interrupt masks, an instruction-set state bit and a five-bit mode field. Software-style status writes are restricted while the mode field reads User.

A single exception-entry request does four things in one clock. It saves the status word into the target mode's saved-status copy. It stores a return address into that mode's private link register. It switches the mode and raises the interrupt masks. The saved-status copy of the current mode is always visible on an output.

Top module: `banked_regfile`

## Requirements
- R1: After reset the status word reads 0x000000D3, which is Supervisor mode with both masks set, T clear and flags clear. Every register, the program counter and every saved status read zero.
- R2: Registers 0 to 7 are the same storage in every mode. Index 15 returns the program-counter register, which captures `pc_nxt` on every clock. A write-port access to index 15 has no effect.
- R3: In FIQ mode (10001), indices 8 to 14 address private copies that no other mode can see.
- R4: IRQ (10010), Supervisor (10011), Abort (10111) and Undefined (11011) each have private copies of indices 13 and 14. In these modes, indices 8 to 12 reach the User copies.
- R5: System mode (11111) uses exactly the User (10000) registers. Any mode encoding outside the seven listed maps to the User registers.
- R6: Reads are combinational. When a register is written and read in the same cycle, the read returns the old value, and the new value appears from the next cycle.
- R7: The status word layout is flags N,Z,C,V in bits 31:28, IRQ mask in bit 7, FIQ mask in bit 6, T in bit 5 and mode in bits 4:0; all other bits read 0. A status write stores every field when the mode is not User. In User mode, only the flags and T change.
- R8: Exception entry happens when `exc_req` is high and `exc_mode` is one of the five exception encodings. In that clock, the target's saved status receives the old status word and the target's index 14 receives `exc_ret`. The mode becomes the target, the IRQ mask is set and T is cleared. The FIQ mask is set only for FIQ entry. The flags are kept.
- R9: An exception request whose `exc_mode` is User, System or an unknown encoding has no effect.
- R10: If an exception entry and a status write occur in the same clock, the exception wins and the status write is dropped. If a register write hits the same physical register as the exception's return-address store, the return address wins. A register write to any other register still happens, and it uses the mode in force before the entry.
- R11: `spsr` shows the saved status of the current mode. It reads zero in User, System and unknown modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 4 | Read port A register number |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B register number |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Register write number |
| wr_data | input | 32 | Register write data |
| pc_nxt | input | 32 | Next program-counter value |
| pc_q | output | 32 | Program-counter register |
| sr_wr_en | input | 1 | Status word write enable |
| sr_wr_data | input | 32 | Status word write data |
| exc_req | input | 1 | Exception entry request |
| exc_mode | input | 5 | Target mode of the entry |
| exc_ret | input | 32 | Return address to store |
| cpsr | output | 32 | Current status word |
| spsr | output | 32 | Saved status of the current mode |

## Verification
Exception entry can fall in the same clock as a status write, or as a register write, and the register write may or may not target the link register the entry stores into. These collisions are driven on purpose. Entry into FIQ is issued together with a status write and a write to the old mode's index 14. A second FIQ entry is issued while FIQ's own index 14 is being written. A behavioural model then judges the outcome: it applies the register write first and lets the exception override it. Its bank table is keyed by mode and index and is compared with every output on each clock, and a random phase mixes all three operations freely.

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    rd_a_idx,
  output logic [DW-1:0] rd_a_data,
  input  logic [3:0]    rd_b_idx,
  output logic [DW-1:0] rd_b_data,
  input  logic          wr_en,
  input  logic [3:0]    wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] pc_nxt,
  output logic [DW-1:0] pc_q,
  input  logic          sr_wr_en,
  input  logic [DW-1:0] sr_wr_data,
  input  logic          exc_req,
  input  logic [4:0]    exc_mode,
  input  logic [DW-1:0] exc_ret,
  output logic [DW-1:0] cpsr,
  output logic [DW-1:0] spsr
);
  localparam logic [4:0] M_USR = 5'b10000;
  localparam logic [4:0] M_FIQ = 5'b10001;
  localparam logic [4:0] M_IRQ = 5'b10010;
  localparam logic [4:0] M_SVC = 5'b10011;
  localparam logic [4:0] M_ABT = 5'b10111;
  localparam logic [4:0] M_UND = 5'b11011;
  localparam int NPHYS = 30;
  localparam int FIQ_HI = 13;
  localparam int LINK_BASE = 18;

  logic [DW-1:0] regs [NPHYS];
  logic [DW-1:0] saved [1:5];
  logic [3:0]    flags_q;
  logic          irq_m_q, fiq_m_q, t_q;
  logic [4:0]    mode_q;

  function automatic logic [2:0] bank_of(input logic [4:0] m);
    case (m)
      M_FIQ:   return 3'd1;
      M_IRQ:   return 3'd2;
      M_SVC:   return 3'd3;
      M_ABT:   return 3'd4;
      M_UND:   return 3'd5;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [4:0] slot(input logic [4:0] m, input logic [3:0] i);
    logic [2:0] b;
    b = bank_of(m);
    if (i < 4'd8) return {1'b0, i};
    if (i < 4'd13) return (b == 3'd1) ? 5'(FIQ_HI + int'(i) - 8) : {1'b0, i};
    return 5'(LINK_BASE + 2 * int'(b) + int'(i) - 13);
  endfunction

  wire [2:0] cur_bank  = bank_of(mode_q);
  wire [2:0] tgt_bank  = bank_of(exc_mode);
  wire       exc_ok    = exc_req && (tgt_bank != 3'd0);
  wire       user_mode = (mode_q == M_USR);

  assign cpsr = {flags_q, {(DW-12){1'b0}}, irq_m_q, fiq_m_q, t_q, mode_q};
  assign spsr = (cur_bank == 3'd0 || cur_bank > 3'd5) ? '0 : saved[cur_bank];
  assign rd_a_data = (rd_a_idx == 4'd15) ? pc_q : regs[slot(mode_q, rd_a_idx)];
  assign rd_b_data = (rd_b_idx == 4'd15) ? pc_q : regs[slot(mode_q, rd_b_idx)];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NPHYS; k++) regs[k] <= '0;
      for (int k = 1; k <= 5; k++) saved[k] <= '0;
      flags_q <= '0;
      irq_m_q <= 1'b1;
      fiq_m_q <= 1'b1;
      t_q     <= 1'b0;
      mode_q  <= M_SVC;
      pc_q    <= '0;
    end else begin
      pc_q <= pc_nxt;
      if (wr_en && wr_idx != 4'd15) regs[slot(mode_q, wr_idx)] <= wr_data;
      if (exc_ok) begin
        saved[tgt_bank] <= cpsr;
        regs[slot(exc_mode, 4'd14)] <= exc_ret;
        mode_q  <= exc_mode;
        irq_m_q <= 1'b1;
        t_q     <= 1'b0;
        if (tgt_bank == 3'd1) fiq_m_q <= 1'b1;
      end else if (sr_wr_en) begin
        flags_q <= sr_wr_data[DW-1 -: 4];
        t_q     <= sr_wr_data[5];
        if (!user_mode) begin
          irq_m_q <= sr_wr_data[7];
          fiq_m_q <= sr_wr_data[6];
          mode_q  <= sr_wr_data[4:0];
        end
      end
    end
  end

  assert_exc_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_ok |=> (cpsr[4:0] == $past(exc_mode)) && cpsr[7] && !cpsr[5] && (spsr == $past(cpsr)));

  assert_fiq_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_ok && exc_mode == M_FIQ) |=> cpsr[6]);

  assert_bad_exc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && !exc_ok && !sr_wr_en) |=> (cpsr == $past(cpsr)));

  assert_user_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (user_mode && !exc_ok) |=> (cpsr[7:6] == $past(cpsr[7:6])) && (cpsr[4:0] == M_USR));

  assert_exc_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_ok && sr_wr_en) |=> (cpsr[DW-1 -: 4] == $past(cpsr[DW-1 -: 4])));
endmodule

// File: tb/sim_banked_regfile.sv
`timescale 1ns/1ps
module sim_banked_regfile;
  logic        clk = 0, rst_n = 0;
  logic [3:0]  rd_a_idx = 0, rd_b_idx = 0, wr_idx = 0;
  logic        wr_en = 0, sr_wr_en = 0, exc_req = 0;
  logic [31:0] wr_data = 0, pc_nxt = 0, sr_wr_data = 0, exc_ret = 0;
  logic [4:0]  exc_mode = 0;
  logic [31:0] rd_a_data, rd_b_data, pc_q, cpsr, spsr;

  banked_regfile u0 (.clk, .rst_n, .rd_a_idx, .rd_a_data, .rd_b_idx, .rd_b_data,
    .wr_en, .wr_idx, .wr_data, .pc_nxt, .pc_q, .sr_wr_en, .sr_wr_data,
    .exc_req, .exc_mode, .exc_ret, .cpsr, .spsr);

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  string tag = "R1";
  logic [31:0] mreg [6][15];
  logic [31:0] msave [6];
  logic [31:0] mcpsr, mpc;

  function automatic int bnk(input logic [4:0] m);
    case (m)
      5'b10001: return 1;
      5'b10010: return 2;
      5'b10011: return 3;
      5'b10111: return 4;
      5'b11011: return 5;
      default:  return 0;
    endcase
  endfunction

  task automatic mwrite(input logic [4:0] m, input int i, input logic [31:0] v);
    int b = bnk(m);
    if (i < 8) begin
      for (int k = 0; k < 6; k++) mreg[k][i] = v;
    end else if (i < 13) begin
      if (b == 1) mreg[1][i] = v;
      else for (int k = 0; k < 6; k++) if (k != 1) mreg[k][i] = v;
    end else mreg[b][i] = v;
  endtask

  function automatic logic [31:0] mread(input logic [3:0] i);
    if (i == 4'd15) return mpc;
    return mreg[bnk(mcpsr[4:0])][i];
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, exp);
    end
  endtask

  task automatic cyc();
    int tb;
    logic [31:0] d;
    #1;
    chk("rd_a", rd_a_data, mread(rd_a_idx));
    chk("rd_b", rd_b_data, mread(rd_b_idx));
    chk("cpsr", cpsr, mcpsr);
    chk("spsr", spsr, (bnk(mcpsr[4:0]) == 0) ? 32'h0 : msave[bnk(mcpsr[4:0])]);
    chk("pc", pc_q, mpc);
    @(posedge clk);
    mpc = pc_nxt;
    if (wr_en && wr_idx != 4'd15) mwrite(mcpsr[4:0], int'(wr_idx), wr_data);
    tb = bnk(exc_mode);
    d = sr_wr_data;
    if (exc_req && tb != 0) begin
      msave[tb] = mcpsr;
      mreg[tb][14] = exc_ret;
      mcpsr = {mcpsr[31:28], 20'h0, 1'b1, (tb == 1) ? 1'b1 : mcpsr[6], 1'b0, exc_mode};
    end else if (sr_wr_en) begin
      if (mcpsr[4:0] == 5'b10000) mcpsr = {d[31:28], 20'h0, mcpsr[7:6], d[5], mcpsr[4:0]};
      else mcpsr = {d[31:28], 20'h0, d[7:0]};
    end
    @(negedge clk);
    wr_en = 0; sr_wr_en = 0; exc_req = 0;
  endtask

  task automatic wr(input int i, input logic [31:0] v);
    wr_en = 1; wr_idx = 4'(i); wr_data = v; cyc();
  endtask
  task automatic srw(input logic [31:0] v);
    sr_wr_en = 1; sr_wr_data = v; cyc();
  endtask
  task automatic sweep(input int lo, input int hi);
    for (int i = lo; i <= hi; i++) begin rd_a_idx = 4'(i); rd_b_idx = 4'(hi - i + lo); cyc(); end
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [4:0] mset [8];
    mset = '{5'b10000, 5'b10001, 5'b10010, 5'b10011, 5'b10111, 5'b11011, 5'b11111, 5'b10101};
    for (int k = 0; k < 6; k++) begin
      msave[k] = 0;
      for (int i = 0; i < 15; i++) mreg[k][i] = 0;
    end
    mcpsr = 32'h000000D3; mpc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R1"; sweep(0, 14);
    tag = "R2";
    for (int i = 0; i < 8; i++) wr(i, 32'h100 + i);
    pc_nxt = 32'h400; rd_a_idx = 15; wr(15, 32'hDEAD);
    sweep(0, 7); rd_a_idx = 15; cyc();
    tag = "R7"; srw(32'hF00000D1);
    tag = "R3";
    for (int i = 8; i < 15; i++) wr(i, 32'h800 + i);
    sweep(8, 14);
    tag = "R7"; srw(32'h00000010);
    for (int i = 8; i < 15; i++) wr(i, 32'h900 + i);
    srw(32'h0000001F); srw(32'h2000003F); srw(32'h000000D2); sweep(8, 14);
    tag = "R8"; exc_req = 1; exc_mode = 5'b10011; exc_ret = 32'hABC; cyc();
    sweep(13, 14);
    tag = "R5"; srw(32'h0000001F); sweep(8, 14);
    srw(32'h00000015); sweep(8, 14);
    tag = "R4"; srw(32'h00000092);
    wr(13, 32'hA13); wr(14, 32'hA14); sweep(8, 14);
    srw(32'h00000097); wr(13, 32'hB13); sweep(8, 14);
    srw(32'h0000009B); wr(14, 32'hC14); sweep(8, 14);
    srw(32'h00000093); sweep(12, 14);
    tag = "R6"; rd_a_idx = 3; rd_b_idx = 3; wr(3, 32'h5555); cyc();
    rd_a_idx = 13; wr(13, 32'h6666); cyc();
    tag = "R11"; exc_req = 1; exc_mode = 5'b11011; exc_ret = 32'h77; cyc(); cyc();
    exc_req = 1; exc_mode = 5'b10010; exc_ret = 32'h78; cyc(); cyc();
    srw(32'h0000001F); cyc();
    tag = "R9";
    exc_req = 1; exc_mode = 5'b10000; cyc();
    exc_req = 1; exc_mode = 5'b11111; cyc();
    exc_req = 1; exc_mode = 5'b10101; rd_a_idx = 14; cyc(); cyc();
    tag = "R10";
    rd_a_idx = 14; rd_b_idx = 8;
    exc_req = 1; exc_mode = 5'b10001; exc_ret = 32'hE1;
    sr_wr_en = 1; sr_wr_data = 32'hF000001F; wr(14, 32'hF14);
    cyc(); srw(32'h0000001F); sweep(13, 14); srw(32'h000000D1);
    rd_a_idx = 14; exc_req = 1; exc_mode = 5'b10001; exc_ret = 32'hE2;
    wr(14, 32'h1234); cyc();
    for (int n = 0; n < 600; n++) begin
      rd_a_idx = 4'($urandom); rd_b_idx = 4'($urandom);
      wr_en = $urandom_range(0, 1) == 1; wr_idx = 4'($urandom); wr_data = $urandom;
      pc_nxt = $urandom;
      sr_wr_en = $urandom_range(0, 3) == 0;
      sr_wr_data = {$urandom} & 32'hF00000FF;
      sr_wr_data[4:0] = mset[$urandom_range(0, 7)];
      exc_req = $urandom_range(0, 5) == 0;
      exc_mode = mset[$urandom_range(0, 7)]; exc_ret = $urandom;
      cyc();
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule